// File: doc/BRIEF.md
# Slope-Indexed ADC Correction Unit

This unit removes the static nonlinearity of one analog-to-digital converter from its sample stream. Each clock it takes two codes that were sampled together. One is the main converter's quantization code. The other comes from a second converter that digitizes a differentiated copy of the input, so that code stands for the instantaneous slope. The upper bits of the main code and the upper bits of the slope code are joined to form an index into a correction RAM. The signed correction read from that RAM is added to the main code. The sum is clamped to the code range and then driven out.

The RAM holds one entry for every pair of amplitude bin and slope bin. It is filled through a host write port with values measured on the specific converter being corrected. After loading, the contents are treated as fixed. While the host signals that a load is under way, or writes an entry, the samples entering in that cycle pass through without correction.

Top module: `slope_corr_unit`

## Requirements
- R1: While `rst_ni` is low and after its release, `corr_valid_o` is 0 and `corr_code_o` is 0 until the first sample arrives at the output.
- R2: The table index is `{main_code_i[MAIN_W-1:MAIN_W-AMP_BITS], slope_code_i[SLOPE_W-1:SLOPE_W-SLP_BITS]}`. The amplitude bits are the upper part of the index and the slope bits are the lower part.
- R3: For a corrected sample, `corr_code_o` equals the unsigned main code plus the two's-complement table entry, when that sum lies within 0 to 2^MAIN_W-1.
- R4: A corrected sum above 2^MAIN_W-1 produces 2^MAIN_W-1.
- R5: A corrected sum below 0 produces 0.
- R6: A sample presented with `sample_valid_i` high in the cycle before rising edge k appears at the outputs with `corr_valid_o` high right after edge k+1, which is a latency of two edges.
- R7: A cycle with `sample_valid_i` low produces `corr_valid_o` low two edges later, and `corr_code_o` keeps its previous value.
- R8: A valid sample presented while `load_active_i` or `tbl_we_i` is high leaves the unit unchanged: `corr_code_o` equals its raw main code.
- R9: A write with `tbl_we_i` high stores `tbl_data_i` at `tbl_addr_i` on that edge. The entry keeps that value until it is written again, and samples that index it in later cycles use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | The main and slope codes are a valid sample pair |
| main_code_i | input | MAIN_W | Main converter code, unsigned |
| slope_code_i | input | SLOPE_W | Slope converter code, unsigned |
| load_active_i | input | 1 | A host table load is under way; correction is bypassed |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | AMP_BITS+SLP_BITS | Table write index |
| tbl_data_i | input | CORR_W | Correction to store, two's complement |
| corr_valid_o | output | 1 | The output code is valid |
| corr_code_o | output | MAIN_W | Corrected (or bypassed) main code |

## Verification
Faults in the index register or the RAM show up two edges later as an output that differs from the main code plus the expected bin's correction. A wrong slope slice usually sends a sample to a neighbouring bin that holds a different value, so the output is off within one sample. A stuck bypass flag or a lost valid flag corrupts the very sample that carried it. A broken clamp shows up only for samples near the code limits whose correction pushes them past the limit. The exhaustive sweep over every amplitude and slope pair reaches those cases.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  // What stage 2 must do with the sample captured in stage 1
  typedef enum logic [1:0] {
    PATH_IDLE   = 2'd0,
    PATH_CORR   = 2'd1,
    PATH_BYPASS = 2'd2
  } path_e;
endpackage

// File: rtl/adc_corr_addr.sv
module adc_corr_addr
  import adc_corr_pkg::*;
#(
  parameter int MAIN_W   = 12,
  parameter int SLOPE_W  = 10,
  parameter int AMP_BITS = 6,
  parameter int SLP_BITS = 4,
  localparam int ADDR_W  = AMP_BITS + SLP_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               bypass_req_i,
  input  logic [MAIN_W-1:0]  main_i,
  input  logic [SLOPE_W-1:0] slope_i,
  output path_e              path_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [MAIN_W-1:0]  main_o
);
  logic [AMP_BITS-1:0] amp_bin;
  logic [SLP_BITS-1:0] slp_bin;
  path_e               path_d;

  assign amp_bin = main_i[MAIN_W-1:MAIN_W-AMP_BITS];
  assign slp_bin = slope_i[SLOPE_W-1:SLOPE_W-SLP_BITS];

  generate
    if (SLP_BITS < SLOPE_W) begin : g_slope_lsb
      logic unused_slope_lsb;
      assign unused_slope_lsb = ^slope_i[SLOPE_W-SLP_BITS-1:0];
    end
  endgenerate

  always_comb begin
    if (!valid_i)          path_d = PATH_IDLE;
    else if (bypass_req_i) path_d = PATH_BYPASS;
    else                   path_d = PATH_CORR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      path_o <= PATH_IDLE;
      addr_o <= '0;
      main_o <= '0;
    end else begin
      path_o <= path_d;
      if (valid_i) begin
        addr_o <= {amp_bin, slp_bin};
        main_o <= main_i;
      end
    end
  end

  // R2: index upper part tracks the captured main code
  a_r2_amp_bin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> addr_o[ADDR_W-1:SLP_BITS] == main_o[MAIN_W-1:MAIN_W-AMP_BITS]);
endmodule

// File: rtl/adc_corr_table.sv
module adc_corr_table #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

  // R9: a write is visible at its index on the next cycle
  a_r9_write_lands: assert property (@(posedge clk_i)
    (we_i && $past(1'b1)) |=> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/adc_corr_apply.sv
module adc_corr_apply
  import adc_corr_pkg::*;
#(
  parameter int MAIN_W = 12,
  parameter int CORR_W = 8,
  localparam int EXT_W = ((MAIN_W > CORR_W) ? MAIN_W : CORR_W) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  path_e             path_i,
  input  logic [MAIN_W-1:0] main_i,
  input  logic [CORR_W-1:0] corr_i,
  output logic              valid_o,
  output logic [MAIN_W-1:0] code_o
);
  logic signed [EXT_W-1:0] main_ext, corr_ext, sum, max_ext;
  logic [MAIN_W-1:0]       sat_code, code_d;

  assign main_ext = {{(EXT_W-MAIN_W){1'b0}}, main_i};
  assign corr_ext = {{(EXT_W-CORR_W){corr_i[CORR_W-1]}}, corr_i};
  assign max_ext  = {{(EXT_W-MAIN_W){1'b0}}, {MAIN_W{1'b1}}};
  assign sum      = main_ext + corr_ext;

  always_comb begin
    if (sum[EXT_W-1])      sat_code = '0;
    else if (sum > max_ext) sat_code = '1;
    else                   sat_code = sum[MAIN_W-1:0];
  end

  always_comb begin
    unique case (path_i)
      PATH_CORR:   code_d = sat_code;
      PATH_BYPASS: code_d = main_i;
      default:     code_d = code_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= (path_i != PATH_IDLE);
      code_o  <= code_d;
    end
  end

  // R4: positive correction never wraps below the raw code
  a_r4_no_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_i == PATH_CORR && !corr_i[CORR_W-1]) |=> code_o >= $past(main_i));
  // R5: negative correction never wraps above the raw code
  a_r5_no_wrap_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_i == PATH_CORR && corr_i[CORR_W-1]) |=> code_o <= $past(main_i));
  // R8: bypassed sample is passed raw
  a_r8_bypass_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_i == PATH_BYPASS) |=> (valid_o && code_o == $past(main_i)));
  // R7: idle slot holds the output
  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_i == PATH_IDLE) |=> (!valid_o && $stable(code_o)));
endmodule

// File: rtl/slope_corr_unit.sv
module slope_corr_unit
  import adc_corr_pkg::*;
#(
  parameter int MAIN_W   = 12,
  parameter int SLOPE_W  = 10,
  parameter int AMP_BITS = 6,
  parameter int SLP_BITS = 4,
  parameter int CORR_W   = 8,
  localparam int ADDR_W  = AMP_BITS + SLP_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_valid_i,
  input  logic [MAIN_W-1:0]  main_code_i,
  input  logic [SLOPE_W-1:0] slope_code_i,
  input  logic               load_active_i,
  input  logic               tbl_we_i,
  input  logic [ADDR_W-1:0]  tbl_addr_i,
  input  logic [CORR_W-1:0]  tbl_data_i,
  output logic               corr_valid_o,
  output logic [MAIN_W-1:0]  corr_code_o
);
  path_e             s1_path;
  logic [ADDR_W-1:0] s1_addr;
  logic [MAIN_W-1:0] s1_main;
  logic [CORR_W-1:0] rd_corr;

  adc_corr_addr #(
    .MAIN_W(MAIN_W), .SLOPE_W(SLOPE_W), .AMP_BITS(AMP_BITS), .SLP_BITS(SLP_BITS)
  ) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (sample_valid_i),
    .bypass_req_i (load_active_i | tbl_we_i),
    .main_i       (main_code_i),
    .slope_i      (slope_code_i),
    .path_o       (s1_path),
    .addr_o       (s1_addr),
    .main_o       (s1_main)
  );

  adc_corr_table #(.ADDR_W(ADDR_W), .DATA_W(CORR_W)) u_table (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (s1_addr),
    .rdata_o (rd_corr)
  );

  adc_corr_apply #(.MAIN_W(MAIN_W), .CORR_W(CORR_W)) u_apply (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .path_i  (s1_path),
    .main_i  (s1_main),
    .corr_i  (rd_corr),
    .valid_o (corr_valid_o),
    .code_o  (corr_code_o)
  );

  // R6: valid input reaches the output two edges later
  a_r6_two_cycle_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> ##1 corr_valid_o);
  // R6: a stage-1 sample always emerges on the next edge
  a_r6_stage_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_path != PATH_IDLE) |=> corr_valid_o);
endmodule

// File: tb/slope_corr_unit_tb_top.sv
module slope_corr_unit_tb_top;
  localparam int MAIN_W   = 6;
  localparam int SLOPE_W  = 5;
  localparam int AMP_BITS = 4;
  localparam int SLP_BITS = 3;
  localparam int CORR_W   = 5;
  localparam int ADDR_W   = AMP_BITS + SLP_BITS;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int CODE_MAX = (1 << MAIN_W) - 1;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               sample_valid_i = 1'b0;
  logic [MAIN_W-1:0]  main_code_i = '0;
  logic [SLOPE_W-1:0] slope_code_i = '0;
  logic               load_active_i = 1'b0;
  logic               tbl_we_i = 1'b0;
  logic [ADDR_W-1:0]  tbl_addr_i = '0;
  logic [CORR_W-1:0]  tbl_data_i = '0;
  logic               corr_valid_o;
  logic [MAIN_W-1:0]  corr_code_o;

  always #4 clk = ~clk;

  slope_corr_unit #(
    .MAIN_W(MAIN_W), .SLOPE_W(SLOPE_W), .AMP_BITS(AMP_BITS),
    .SLP_BITS(SLP_BITS), .CORR_W(CORR_W)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(sample_valid_i),
    .main_code_i(main_code_i), .slope_code_i(slope_code_i),
    .load_active_i(load_active_i), .tbl_we_i(tbl_we_i),
    .tbl_addr_i(tbl_addr_i), .tbl_data_i(tbl_data_i),
    .corr_valid_o(corr_valid_o), .corr_code_o(corr_code_o)
  );

  int checks = 0, failures = 0;
  int model_tbl [DEPTH];
  bit done = 0;
  // two-deep expectation pipeline
  bit    p_v[2];
  int    p_code[2];
  string p_tag[2];
  int    last_code = 0;

  function automatic int tbl_val(int a);
    return ((a * 7 + 3) % 32) - 16;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // call at negedge: check output of sample from two steps ago, then drive new one
  task automatic step(bit v, int m, int s, bit load, bit we, int wa, int wd);
    int    ec;
    string tg;
    chk({p_tag[1], " valid (R6)"}, corr_valid_o, p_v[1]);
    chk({p_tag[1], " code"}, corr_code_o, p_code[1]);
    if (!v) begin
      ec = last_code; tg = "R7";
    end else if (load || we) begin
      ec = m; tg = "R8";
    end else begin
      int idx, sum;
      // R2: index = {main[5:2], slope[4:2]}
      idx = ((m >> 2) << SLP_BITS) | (s >> 2);
      sum = m + model_tbl[idx];
      if (sum > CODE_MAX)  begin ec = CODE_MAX; tg = "R4"; end
      else if (sum < 0)    begin ec = 0;        tg = "R5"; end
      else                 begin ec = sum;      tg = "R3 R2"; end
    end
    if (v) last_code = ec;
    p_v[1] = p_v[0]; p_code[1] = p_code[0]; p_tag[1] = p_tag[0];
    p_v[0] = v; p_code[0] = ec; p_tag[0] = tg;
    sample_valid_i = v;
    main_code_i    = MAIN_W'(m);
    slope_code_i   = SLOPE_W'(s);
    load_active_i  = load;
    tbl_we_i       = we;
    tbl_addr_i     = ADDR_W'(wa);
    tbl_data_i     = CORR_W'(wd);
    if (we) model_tbl[wa] = wd;
    @(negedge clk);
  endtask

  initial begin
    p_v[0] = 0; p_v[1] = 0; p_code[0] = 0; p_code[1] = 0;
    p_tag[0] = "R1"; p_tag[1] = "R1";
    repeat (3) @(negedge clk);
    chk("R1 reset valid", corr_valid_o, 0);
    chk("R1 reset code", corr_code_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release valid", corr_valid_o, 0);
    chk("R1 after release code", corr_code_o, 0);
    // load table; samples during load are bypassed (R8, R9)
    for (int a = 0; a < DEPTH; a++)
      step(1, (a * 5) % 64, a % 32, 1, 1, a, tbl_val(a));
    step(1, 17, 9, 1, 0, 0, 0);
    step(1, 63, 31, 1, 0, 0, 0);
    // exhaustive sweep with periodic idle slots
    for (int m = 0; m <= CODE_MAX; m++)
      for (int s = 0; s < (1 << SLOPE_W); s++) begin
        step(1, m, s, 0, 0, 0, 0);
        if (((m * 32 + s) % 17) == 5) step(0, 3, 3, 0, 0, 0, 0);
      end
    // R9: rewrite one entry, then use it
    step(1, 20, 12, 0, 1, (5 << SLP_BITS) | 3, 15);
    step(1, 20, 12, 0, 0, 0, 0);
    step(1, 21, 13, 0, 1, (5 << SLP_BITS) | 3, -16);
    step(1, 21, 13, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule